// File: doc/BRIEF.md
# Prioritised Interrupt Collector with Host Non-Maskable Request

This block gathers interrupt events for a processor core. Two asynchronous pins from outside the chip and three event strobes from inside it set bits in a pending register. An enable register, written by software, decides which pending bits may raise a request. The core sees one request line. A vector index names the winning source, and a flag tells the core whether to push its state before it enters the handler.

A host can raise a non-maskable request by writing a control word. The enable register has no effect on it, and it wins over every maskable source. The same write loads a mode bit. When that bit is set, the core is told not to save its state, so the host can take control before the stack pointer holds a valid value. The request clears itself when the core acknowledges it. Maskable pending bits stay set until software clears them by writing ones.

Top module: `irq_hub`

## Requirements
- R1: While reset is low and on the first cycle after it, pending_o, enable_o, irq_req_o, irq_nmi_o and irq_vec_o are all zero and save_state_o is one.
- R2: A pin of ext_irq_i passes through two synchronising flip-flops. Only a low-to-high change sets its pending bit (pin k sets bit k), on the third rising clock edge after the pin rises. A pin held high does not set the bit again after it has been cleared.
- R3: When bit k of int_evt_i is high at a clock edge, pending bit 2+k is set after that edge. Bit 0 is the window-violation write, bit 1 the host request and bit 2 the display-line match.
- R4: A write with sw_addr_i=1 clears each pending bit whose sw_wdata_i bit is one and leaves the others alone. If a new event for a bit arrives in the same cycle, the bit stays set. Pending bits never fall in any other way.
- R5: A write with sw_addr_i=0 loads enable_o from sw_wdata_i. A pending bit whose enable bit is zero stays visible on pending_o but raises no request. irq_req_o is zero when no enabled bit is pending and no non-maskable request is present.
- R6: With no non-maskable request, irq_vec_o gives the lowest index among the bits that are both pending and enabled. It reads 0 when there is no request.
- R7: A host write (host_wr_i) with host_nmi_i=1 sets the non-maskable request after the edge, whatever enable_o holds. irq_nmi_o and irq_req_o are then high and irq_vec_o is 5, above any maskable source.
- R8: Every host write loads the mode bit from host_nosave_i. save_state_o equals the inverse of the mode bit while irq_nmi_o is high, and is one at all other times.
- R9: irq_ack_i while irq_nmi_o is high clears the non-maskable request after the edge, unless a new host request arrives in the same cycle. irq_ack_i never changes the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_irq_i | input | 2 | Asynchronous external interrupt pins |
| int_evt_i | input | 3 | Internal event strobes (window violation, host request, line match) |
| sw_we_i | input | 1 | Software register write strobe |
| sw_addr_i | input | 1 | 0 = enable register, 1 = pending clear |
| sw_wdata_i | input | 5 | Software write data |
| host_wr_i | input | 1 | Host control word write strobe |
| host_nmi_i | input | 1 | Host control word: raise non-maskable request |
| host_nosave_i | input | 1 | Host control word: skip state save on that request |
| irq_ack_i | input | 1 | Core acknowledges the current request |
| pending_o | output | 5 | Pending register read value |
| enable_o | output | 5 | Enable register read value |
| irq_req_o | output | 1 | Request to the core |
| irq_nmi_o | output | 1 | Current request is non-maskable |
| irq_vec_o | output | 3 | Index of the winning source (5 = non-maskable) |
| save_state_o | output | 1 | Core must push its state on entry |

## Verification
The bench targets the case where a new event and a clear for the same bit land in one cycle. A design that lets the clear win silently loses an interrupt. It holds an external pin high across a clear, so a level-sensitive design would show the bit set again. It raises a host request over enabled maskable sources with the no-save mode set, and checks that the vector, the request and save_state_o switch together. If the mode bit had the wrong polarity, the core would push state onto an invalid stack. It then acknowledges both kinds of request, because acknowledging a maskable source must leave the pending bits alone and acknowledging the host request must drop it.

// File: rtl/irq_hub_pkg.sv
// Package: shared constants and types for the interrupt collector.
// Assumes: default source counts are 2 external pins and 3 internal events.
package irq_hub_pkg;

    localparam int unsigned EXT_DEF   = 2;
    localparam int unsigned INT_DEF   = 3;
    localparam int unsigned SYNC_DEF  = 2;

    // Software register select values on sw_addr_i.
    typedef enum logic {
        SEL_ENABLE   = 1'b0,
        SEL_PEND_CLR = 1'b1
    } sw_sel_e;

endpackage

// File: rtl/irq_hub_sync.sv
// Module: synchronises asynchronous pins and detects their rising edges.
// Assumes: STAGES >= 2; an edge pulse lasts one cycle, and the cycle after
// the last synchroniser stage goes high.
module irq_hub_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] rise_o
);

    localparam int unsigned CHAIN = STAGES + 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [CHAIN-1:0] chain_q;

        // Shift the pin through the synchroniser and a history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], pin_i[g]};
            end
        end

        // Rising edge: last synchroniser stage high, history stage low.
        always_comb begin
            rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        end
    end

endmodule

// File: rtl/irq_hub_pend.sv
// Module: holds the pending and enable registers.
// Assumes: a set wins over a write-one clear in the same cycle; enable is
// loaded whole by a software write with the enable select.
module irq_hub_pend
    import irq_hub_pkg::*;
#(
    parameter int unsigned N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             sw_we_i,
    input  logic             sw_addr_i,
    input  logic [N_SRC-1:0] sw_wdata_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] en_o
);

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] clr_mask;
    logic             wr_en_reg;

    // Decode the software write into a clear mask and an enable load.
    always_comb begin
        clr_mask  = '0;
        wr_en_reg = 1'b0;
        if (sw_we_i) begin
            if (sw_sel_e'(sw_addr_i) == SEL_PEND_CLR) begin
                clr_mask = sw_wdata_i;
            end else begin
                wr_en_reg = 1'b1;
            end
        end
    end

    // Update pending bits: clear selected bits, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | set_i;
        end
    end

    // Load the enable register on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en_reg) begin
            en_q <= sw_wdata_i;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;

endmodule

// File: rtl/irq_hub_nmi.sv
// Module: host non-maskable request and its state-save mode bit.
// Assumes: every host write loads the mode bit; a new host request in the
// same cycle as an acknowledge keeps the request set.
module irq_hub_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr_i,
    input  logic host_nmi_i,
    input  logic host_nosave_i,
    input  logic ack_i,
    output logic nmi_o,
    output logic nosave_o
);

    logic nmi_q;
    logic nosave_q;
    logic nmi_set;

    // A host write with the request bit set raises the request.
    always_comb begin
        nmi_set = host_wr_i & host_nmi_i;
    end

    // Hold the request until the core acknowledges it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else if (nmi_set) begin
            nmi_q <= 1'b1;
        end else if (ack_i && nmi_q) begin
            nmi_q <= 1'b0;
        end
    end

    // Capture the state-save mode on every host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nosave_q <= 1'b0;
        end else if (host_wr_i) begin
            nosave_q <= host_nosave_i;
        end
    end

    assign nmi_o    = nmi_q;
    assign nosave_o = nosave_q;

endmodule

// File: rtl/irq_hub_arb.sv
// Module: fixed-priority arbiter over the maskable sources plus the host
// non-maskable request.
// Assumes: the non-maskable request is index N_SRC and beats all others;
// among maskable sources the lowest index wins; vector reads 0 when idle.
module irq_hub_arb #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned VEC_W = 3
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             nmi_i,
    input  logic             nosave_i,
    output logic             req_o,
    output logic             nmi_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             save_o
);

    logic [N_SRC-1:0] active;
    logic [VEC_W-1:0] low_idx;

    // Find the lowest-index source that is both pending and enabled.
    always_comb begin
        active  = pend_i & en_i;
        low_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                low_idx = VEC_W'(i);
            end
        end
    end

    // Merge in the non-maskable request and form the core outputs.
    always_comb begin
        req_o  = nmi_i | (|active);
        nmi_o  = nmi_i;
        vec_o  = nmi_i ? VEC_W'(N_SRC) : low_idx;
        save_o = nmi_i ? ~nosave_i : 1'b1;
    end

endmodule

// File: rtl/irq_hub.sv
// Module: top of the interrupt collector. Synchronises the external pins,
// records events as pending, masks them with the enable register and
// presents one prioritised request to the core.
// Assumes: internal event strobes are already in the clk domain; software
// and host writes are single-cycle strobes.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned N_EXT  = EXT_DEF,
    parameter int unsigned N_INT  = INT_DEF,
    parameter int unsigned STAGES = SYNC_DEF,
    localparam int unsigned N_SRC = N_EXT + N_INT,
    localparam int unsigned VEC_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_INT-1:0] int_evt_i,
    input  logic             sw_we_i,
    input  logic             sw_addr_i,
    input  logic [N_SRC-1:0] sw_wdata_i,
    input  logic             host_wr_i,
    input  logic             host_nmi_i,
    input  logic             host_nosave_i,
    input  logic             irq_ack_i,
    output logic [N_SRC-1:0] pending_o,
    output logic [N_SRC-1:0] enable_o,
    output logic             irq_req_o,
    output logic             irq_nmi_o,
    output logic [VEC_W-1:0] irq_vec_o,
    output logic             save_state_o
);

    logic [N_EXT-1:0] ext_rise;
    logic [N_SRC-1:0] set_vec;
    logic             nmi_q;
    logic             nosave_q;

    irq_hub_sync #(
        .WIDTH  (N_EXT),
        .STAGES (STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_irq_i),
        .rise_o (ext_rise)
    );

    // External edges take the low indices, internal events the high ones.
    always_comb begin
        set_vec = {int_evt_i, ext_rise};
    end

    irq_hub_pend #(
        .N_SRC (N_SRC)
    ) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .sw_we_i    (sw_we_i),
        .sw_addr_i  (sw_addr_i),
        .sw_wdata_i (sw_wdata_i),
        .pend_o     (pending_o),
        .en_o       (enable_o)
    );

    irq_hub_nmi i_nmi (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_i     (host_wr_i),
        .host_nmi_i    (host_nmi_i),
        .host_nosave_i (host_nosave_i),
        .ack_i         (irq_ack_i),
        .nmi_o         (nmi_q),
        .nosave_o      (nosave_q)
    );

    irq_hub_arb #(
        .N_SRC (N_SRC),
        .VEC_W (VEC_W)
    ) i_arb (
        .pend_i   (pending_o),
        .en_i     (enable_o),
        .nmi_i    (nmi_q),
        .nosave_i (nosave_q),
        .req_o    (irq_req_o),
        .nmi_o    (irq_nmi_o),
        .vec_o    (irq_vec_o),
        .save_o   (save_state_o)
    );

endmodule

// File: rtl/irq_hub_chk.sv
// Module: property checker for irq_hub, attached through bind.
// Assumes: observes the top-level ports only.
module irq_hub_chk #(
    parameter int unsigned N_EXT  = 2,
    parameter int unsigned N_INT  = 3,
    localparam int unsigned N_SRC = N_EXT + N_INT,
    localparam int unsigned VEC_W = $clog2(N_SRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_INT-1:0] int_evt_i,
    input logic             sw_we_i,
    input logic             sw_addr_i,
    input logic             host_wr_i,
    input logic             host_nmi_i,
    input logic             host_nosave_i,
    input logic             irq_ack_i,
    input logic [N_SRC-1:0] pending_o,
    input logic [N_SRC-1:0] enable_o,
    input logic             irq_req_o,
    input logic             irq_nmi_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic             save_state_o
);

    logic [N_SRC-1:0] act;
    logic [N_SRC-1:0] win_bit;
    logic             win_hit;
    logic             lower_hit;

    // Relate the vector to the pending and enable values seen at the ports.
    always_comb begin
        act       = pending_o & enable_o;
        win_bit   = N_SRC'(1) << irq_vec_o;
        win_hit   = |(act & win_bit);
        lower_hit = |(act & (win_bit - N_SRC'(1)));
    end

    // R7: a host request shows up as a non-maskable request on the next cycle.
    assert_nmi_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_nmi_i) |=> (irq_nmi_o && irq_req_o));

    // R8: the mode written with the host request decides the state save.
    assert_nmi_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_nmi_i) |=> (save_state_o == !$past(host_nosave_i)));

    // R8: maskable requests always save state.
    assert_mask_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_nmi_o |-> save_state_o);

    // R9: an acknowledge drops the host request when no new one arrives.
    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_nmi_o && !(host_wr_i && host_nmi_i)) |=> !irq_nmi_o);

    // R3: internal events set their pending bits.
    assert_int_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_evt_i) |=>
        ((pending_o[N_SRC-1:N_EXT] & $past(int_evt_i)) == $past(int_evt_i)));

    // R4: without a clear write no pending bit falls.
    assert_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_we_i && sw_addr_i) |=> ((pending_o & $past(pending_o)) == $past(pending_o)));

    // R5: idle request line means nothing enabled is pending.
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> ((act == '0) && !irq_nmi_o));

    // R6: a maskable winner is active and no lower index is active.
    assert_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !irq_nmi_o) |-> (win_hit && !lower_hit));

endmodule

bind irq_hub irq_hub_chk #(.N_EXT(N_EXT), .N_INT(N_INT)) i_irq_hub_chk (.*);

// File: tb/test_irq_hub.sv
module test_irq_hub;

    localparam int N_SRC = 5;
    localparam int VEC_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ext_irq = '0;
    logic [2:0]       int_evt = '0;
    logic             sw_we = 1'b0;
    logic             sw_addr = 1'b0;
    logic [N_SRC-1:0] sw_wdata = '0;
    logic             host_wr = 1'b0;
    logic             host_nmi = 1'b0;
    logic             host_nosave = 1'b0;
    logic             ack = 1'b0;
    logic [N_SRC-1:0] pending;
    logic [N_SRC-1:0] enable;
    logic             irq_req;
    logic             irq_nmi;
    logic [VEC_W-1:0] irq_vec;
    logic             save_state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    logic [1:0]       m_s1 = '0, m_s2 = '0, m_s3 = '0;
    logic [N_SRC-1:0] m_pend = '0, m_en = '0;
    logic             m_nmi = 1'b0, m_nosave = 1'b0;

    always #5 clk = ~clk;

    irq_hub i_irq_hub (
        .clk (clk), .rst_n (rst_n), .ext_irq_i (ext_irq), .int_evt_i (int_evt),
        .sw_we_i (sw_we), .sw_addr_i (sw_addr), .sw_wdata_i (sw_wdata),
        .host_wr_i (host_wr), .host_nmi_i (host_nmi), .host_nosave_i (host_nosave),
        .irq_ack_i (ack), .pending_o (pending), .enable_o (enable),
        .irq_req_o (irq_req), .irq_nmi_o (irq_nmi), .irq_vec_o (irq_vec),
        .save_state_o (save_state)
    );

    function automatic logic [VEC_W-1:0] exp_vec();
        logic [N_SRC-1:0] a = m_pend & m_en;
        if (m_nmi) return VEC_W'(N_SRC);
        for (int i = 0; i < N_SRC; i++) if (a[i]) return VEC_W'(i);
        return '0;
    endfunction

    function automatic logic exp_req();
        return m_nmi || ((m_pend & m_en) != '0);
    endfunction

    function automatic logic exp_save();
        return m_nmi ? !m_nosave : 1'b1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        int_evt = '0; sw_we = 1'b0; sw_addr = 1'b0; sw_wdata = '0;
        host_wr = 1'b0; host_nmi = 1'b0; host_nosave = 1'b0; ack = 1'b0;
    endtask

    // Apply the current inputs for one edge, advance the model, check ports.
    task automatic step(string ptag);
        logic [N_SRC-1:0] clr;
        @(posedge clk);
        clr = (sw_we && sw_addr) ? sw_wdata : '0;
        m_pend = (m_pend & ~clr) | {int_evt, (m_s2 & ~m_s3)};
        if (sw_we && !sw_addr) m_en = sw_wdata;
        if (host_wr && host_nmi) m_nmi = 1'b1;
        else if (ack && m_nmi) m_nmi = 1'b0;
        if (host_wr) m_nosave = host_nosave;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_irq;
        @(negedge clk);
        check(ptag, 32'(pending), 32'(m_pend));
        check("R5 enable", 32'(enable), 32'(m_en));
        check("R5 request", 32'(irq_req), 32'(exp_req()));
        check("R6 vector", 32'(irq_vec), 32'(exp_vec()));
        check("R7 nmi", 32'(irq_nmi), 32'(m_nmi));
        check("R8 save", 32'(save_state), 32'(exp_save()));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N_SRC-1:0] saved;
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        // R1: reset values during and right after reset.
        check("R1 pending", 32'(pending), 0);
        check("R1 req", 32'(irq_req), 0);
        check("R1 save", 32'(save_state), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enable", 32'(enable), 0);
        check("R1 vector", 32'(irq_vec), 0);

        // R2: edge on pin 0 sets bit 0 on the third edge, level does not re-set.
        sw_we = 1'b1; sw_addr = 1'b0; sw_wdata = 5'h1F; step("R5 pend");
        idle_inputs();
        ext_irq = 2'b01;
        step("R2 pend"); step("R2 pend");
        check("R2 not yet", 32'(pending[0]), 0);
        step("R2 pend");
        check("R2 set on edge", 32'(pending[0]), 1);
        check("R6 vector ext0", 32'(irq_vec), 0);
        sw_we = 1'b1; sw_addr = 1'b1; sw_wdata = 5'h01; step("R4 pend");
        idle_inputs();
        repeat (4) step("R2 pend");
        check("R2 level ignored", 32'(pending[0]), 0);
        ext_irq = 2'b00;
        repeat (4) step("R2 pend");

        // R3 + R4: event and clear on the same bit in one cycle, event wins.
        int_evt = 3'b001; sw_we = 1'b1; sw_addr = 1'b1; sw_wdata = 5'h04;
        step("R4 pend");
        idle_inputs();
        check("R4 set beats clear", 32'(pending[2]), 1);
        int_evt = 3'b100; step("R3 pend"); idle_inputs();
        check("R3 line match bit4", 32'(pending[4]), 1);
        check("R6 lowest wins", 32'(irq_vec), 2);

        // R7 + R8: host request with no-save mode over enabled sources.
        host_wr = 1'b1; host_nmi = 1'b1; host_nosave = 1'b1; step("R7 pend");
        idle_inputs();
        check("R7 nmi vector", 32'(irq_vec), 5);
        check("R8 no save", 32'(save_state), 0);
        saved = pending;
        ack = 1'b1; step("R9 pend"); idle_inputs();
        check("R9 nmi cleared", 32'(irq_nmi), 0);
        check("R8 save after nmi", 32'(save_state), 1);
        ack = 1'b1; step("R9 pend"); idle_inputs();
        check("R9 ack keeps pending", 32'(pending), 32'(saved));

        // R5: masking everything removes the request but keeps pending.
        sw_we = 1'b1; sw_addr = 1'b0; sw_wdata = '0; step("R5 pend"); idle_inputs();
        check("R5 masked req", 32'(irq_req), 0);
        check("R5 pending kept", 32'(pending), 32'(saved));

        // R7 + R9: new host request in the same cycle as an acknowledge.
        host_wr = 1'b1; host_nmi = 1'b1; step("R7 pend"); idle_inputs();
        host_wr = 1'b1; host_nmi = 1'b1; ack = 1'b1; step("R9 pend"); idle_inputs();
        check("R9 new request kept", 32'(irq_nmi), 1);
        ack = 1'b1; step("R9 pend"); idle_inputs();

        // Random traffic checked against the model.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(7) == 0) ext_irq = 2'($urandom);
            int_evt  = ($urandom_range(5) == 0) ? 3'($urandom) : 3'b000;
            sw_we    = ($urandom_range(5) == 0);
            sw_addr  = 1'($urandom);
            sw_wdata = 5'($urandom);
            host_wr  = ($urandom_range(29) == 0);
            host_nmi = 1'($urandom);
            host_nosave = 1'($urandom);
            ack      = ($urandom_range(3) == 0);
            step("R4 random pend");
        end
        idle_inputs();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule